// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block watches a 16-bit processor address bus and compares it every cycle with a break address that software programs as two bytes. When breaks are enabled and the bus address equals the programmed value, the block sets a sticky active flag. It also asks the processor to enter a break. The request is only presented at an instruction boundary. A match seen partway through an instruction is held as pending until the cycle that the processor marks as the last one of its current instruction. A match seen on that last cycle produces the request on the very next cycle.

The request stays up until the processor acknowledges it. While it is serviced, the block drives the address of the vector the processor should fetch. That address has one value in normal operation and another when monitor mode is active. Software reaches the break address bytes and the enable/active control byte through a small byte-wide register port. An external clear-permission input decides whether software may clear the active flag while a break is still outstanding.

Top module: `addr_break_ctrl`

## Requirements
- R1: After reset, `break_req` is 0, and the high address byte, the low address byte and the control byte all read 0x00.
- R2: A write at offset 0x0C stores the high break-address byte (address bits 15..8), and a write at 0x0D stores the low byte (bits 7..0). Both read back unchanged. The control byte at 0x0E reads as {enable, active, 6'b0}. Any other offset reads 0x00, and `reg_rdata` is 0x00 whenever `reg_rd` is 0.
- R3: While the enable bit (control bit 7) is 0, an address equal to the break address neither sets the active flag nor raises `break_req`.
- R4: While enabled, a cycle in which `addr` equals the break address sets the active flag (control bit 6). The flag reads as 1 from the next cycle on.
- R5: An enabled match in a cycle where `last_cycle` is 1 raises `break_req` in the next cycle.
- R6: An enabled match while `last_cycle` is 0 does not raise `break_req` at once. The request is held and appears in the cycle after the next cycle that has `last_cycle` = 1.
- R7: Once raised, `break_req` stays 1 until a cycle with `break_ack` = 1, and is 0 in the cycle after that one.
- R8: `vector_addr` is 0xFFFC while `monitor_mode` is 0 and 0xFEFC while it is 1.
- R9: Writing the control byte with bit 6 = 0 clears the active flag when `clr_en` is 1 or no break is requested or pending. Otherwise the flag is left as it was. Writing bit 6 = 1 never sets the flag.
- R10: When an enabled match and a clearing write to the control byte fall in the same cycle, the active flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| last_cycle | input | 1 | High on the final cycle of the current instruction |
| monitor_mode | input | 1 | Selects the monitor-mode break vector |
| clr_en | input | 1 | Allows the active flag to be cleared while a break is outstanding |
| break_ack | input | 1 | Processor acknowledges the break request |
| break_req | output | 1 | Break request to the processor |
| vector_addr | output | 16 | Address of the vector to load on a break |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Register read data |

## Verification
An address match that sets the active flag can land in the same cycle as a software write that clears it. Match detection can also coincide with an instruction boundary. The bench forces both collisions directly: it issues a clearing control write while the bus holds the break address, and it presents matches with and without `last_cycle`. A random phase then mixes matches, boundaries, acknowledges, clear permission and register writes freely. Every cycle, a bench model derived from the requirements predicts the request line and the control byte, and both are compared against that prediction.

// File: rtl/addr_break_ctrl.sv
module addr_break_ctrl #(
  parameter int RW = 8,
  parameter int OW = 8,
  parameter logic [OW-1:0] OFS_HI  = 8'h0C,
  parameter logic [OW-1:0] OFS_LO  = 8'h0D,
  parameter logic [OW-1:0] OFS_CTL = 8'h0E,
  parameter logic [2*RW-1:0] VEC_NORM = 16'hFFFC,
  parameter logic [2*RW-1:0] VEC_MON  = 16'hFEFC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*RW-1:0] addr,
  input  logic           last_cycle,
  input  logic           monitor_mode,
  input  logic           clr_en,
  input  logic           break_ack,
  output logic           break_req,
  output logic [2*RW-1:0] vector_addr,
  input  logic [OW-1:0]  reg_addr,
  input  logic [RW-1:0]  reg_wdata,
  input  logic           reg_wr,
  input  logic           reg_rd,
  output logic [RW-1:0]  reg_rdata
);
  localparam int EN_BIT  = RW - 1;
  localparam int ACT_BIT = RW - 2;

  logic [RW-1:0] brk_hi, brk_lo;
  logic en, act, pend, req;
  logic match, busy, clr_act, trig;
  logic sel_hi, sel_lo, sel_ctl;
  logic [RW-1:0] rd_val;
  logic unused_bits;

  assign sel_hi  = reg_addr == OFS_HI;
  assign sel_lo  = reg_addr == OFS_LO;
  assign sel_ctl = reg_addr == OFS_CTL;

  assign match   = en && (addr == {brk_hi, brk_lo});
  assign busy    = req || pend;
  assign clr_act = reg_wr && sel_ctl && !reg_wdata[ACT_BIT] && (clr_en || !busy);
  assign trig    = (match && !req) || pend;

  assign unused_bits = ^reg_wdata[RW-3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_hi <= '0;
      brk_lo <= '0;
      en     <= 1'b0;
      act    <= 1'b0;
      pend   <= 1'b0;
      req    <= 1'b0;
    end else begin
      if (reg_wr && sel_hi)  brk_hi <= reg_wdata;
      if (reg_wr && sel_lo)  brk_lo <= reg_wdata;
      if (reg_wr && sel_ctl) en     <= reg_wdata[EN_BIT];

      if (match)        act <= 1'b1;
      else if (clr_act) act <= 1'b0;

      if (req) begin
        if (break_ack) req <= 1'b0;
      end else if (trig && last_cycle) begin
        req  <= 1'b1;
        pend <= 1'b0;
      end else if (trig) begin
        pend <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel_hi)       rd_val = brk_hi;
    else if (sel_lo)  rd_val = brk_lo;
    else if (sel_ctl) rd_val = {en, act, {(RW-2){1'b0}}};
  end

  assign reg_rdata   = reg_rd ? rd_val : '0;
  assign break_req   = req;
  assign vector_addr = monitor_mode ? VEC_MON : VEC_NORM;
endmodule

// File: rtl/addr_break_ctrl_chk.sv
module addr_break_ctrl_chk #(
  parameter int AW = 16,
  parameter int RW = 8,
  parameter int OW = 8,
  parameter logic [OW-1:0] CTL_OFS = 8'h0E
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          last_cycle,
  input logic          break_ack,
  input logic          break_req,
  input logic          reg_rd,
  input logic [OW-1:0] reg_addr,
  input logic [RW-1:0] reg_rdata,
  input logic          en,
  input logic          act,
  input logic [RW-1:0] brk_hi,
  input logic [RW-1:0] brk_lo
);
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    break_req && !break_ack |=> break_req);

  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    break_req && break_ack |=> !break_req);

  p_req_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_req) |-> $past(last_cycle));

  p_act_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> $past(en && (addr == {brk_hi, brk_lo})));

  p_no_set_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !act |=> !act);

  p_ctl_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && (reg_addr == CTL_OFS) |-> reg_rdata[RW-3:0] == '0);
endmodule

bind addr_break_ctrl addr_break_ctrl_chk u_chk (.*);

// File: tb/addr_break_ctrl_test.sv
module addr_break_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] addr = '0;
  logic last_cycle = 0, monitor_mode = 0, clr_en = 0, break_ack = 0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic break_req;
  logic [15:0] vector_addr;
  logic [7:0] reg_rdata;

  addr_break_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .last_cycle(last_cycle),
    .monitor_mode(monitor_mode), .clr_en(clr_en), .break_ack(break_ack),
    .break_req(break_req), .vector_addr(vector_addr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m_hi = 0, m_lo = 0;
  logic m_en = 0, m_act = 0, m_pend = 0, m_req = 0;

  function automatic logic [15:0] exp_vec(input logic mon);
    return mon ? 16'hFEFC : 16'hFFFC;
  endfunction

  function automatic logic [7:0] exp_ctl();
    return {m_en, m_act, 6'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    logic mm, bz, cl, tg;
    logic n_hi, n_lo;
    logic [7:0] nh, nl;
    logic ne, na, np, nr;
    mm = m_en && (addr == {m_hi, m_lo});
    bz = m_req || m_pend;
    cl = reg_wr && reg_addr == 8'h0E && !reg_wdata[6] && (clr_en || !bz);
    tg = (mm && !m_req) || m_pend;
    n_hi = reg_wr && reg_addr == 8'h0C;
    n_lo = reg_wr && reg_addr == 8'h0D;
    nh = n_hi ? reg_wdata : m_hi;
    nl = n_lo ? reg_wdata : m_lo;
    ne = (reg_wr && reg_addr == 8'h0E) ? reg_wdata[7] : m_en;
    na = mm ? 1'b1 : (cl ? 1'b0 : m_act);
    np = m_pend; nr = m_req;
    if (m_req) begin
      if (break_ack) nr = 1'b0;
    end else if (tg && last_cycle) begin
      nr = 1'b1; np = 1'b0;
    end else if (tg) begin
      np = 1'b1;
    end
    @(posedge clk);
    #1;
    m_hi = nh; m_lo = nl; m_en = ne; m_act = na; m_pend = np; m_req = nr;
    chk("break_req model R5 R6 R7", break_req, m_req);
    chk("vector_addr R8", vector_addr, exp_vec(monitor_mode));
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; reg_rd = 1;
    #1;
    chk(tag, reg_rdata, exp);
    reg_rd = 0; reg_addr = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0; reg_addr = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0B7E_A110));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("reset break_req R1", break_req, 0);
    rd(8'h0C, 8'h00, "reset hi R1");
    rd(8'h0D, 8'h00, "reset lo R1");
    rd(8'h0E, 8'h00, "reset ctl R1");

    wr(8'h0C, 8'h12); wr(8'h0D, 8'h34); wr(8'h0E, 8'h80);
    rd(8'h0C, 8'h12, "hi readback R2");
    rd(8'h0D, 8'h34, "lo readback R2");
    rd(8'h0E, 8'h80, "ctl readback R2");
    rd(8'h05, 8'h00, "unmapped read R2");
    reg_addr = 8'h0C; #1 chk("rdata idle R2", reg_rdata, 0); reg_addr = 0;
    wr(8'h0E, 8'hFF);
    rd(8'h0E, 8'h80, "write 1 to active does not set R9");

    wr(8'h0E, 8'h00);
    addr = 16'h1234; last_cycle = 1; tick();
    chk("disabled no request R3", break_req, 0);
    rd(8'h0E, 8'h00, "disabled no flag R3");
    addr = 0; last_cycle = 0;

    wr(8'h0E, 8'h80);
    addr = 16'h1234; last_cycle = 1; tick();
    chk("match on last cycle R5", break_req, 1);
    rd(8'h0E, 8'hC0, "active set R4");
    addr = 0; last_cycle = 0;
    tick(); tick();
    chk("request held R7", break_req, 1);
    clr_en = 0; wr(8'h0E, 8'h80);
    rd(8'h0E, 8'hC0, "clear blocked during break R9");
    clr_en = 1; wr(8'h0E, 8'h80);
    rd(8'h0E, 8'h80, "clear allowed by clr_en R9");
    break_ack = 1; tick(); break_ack = 0;
    chk("request drops after ack R7", break_req, 0);

    addr = 16'h1234; last_cycle = 0; tick();
    chk("mid-instruction match deferred R6", break_req, 0);
    rd(8'h0E, 8'hC0, "active set mid R4");
    addr = 0; tick();
    chk("still deferred R6", break_req, 0);
    last_cycle = 1; tick(); last_cycle = 0;
    chk("request after boundary R6", break_req, 1);
    break_ack = 1; tick(); break_ack = 0;

    clr_en = 0; wr(8'h0E, 8'h80);
    rd(8'h0E, 8'h80, "clear when idle R9");

    clr_en = 1; addr = 16'h1234;
    wr(8'h0E, 8'h80);
    rd(8'h0E, 8'hC0, "set wins over clear R10");
    addr = 0; last_cycle = 1; tick(); last_cycle = 0;
    break_ack = 1; tick(); break_ack = 0;

    monitor_mode = 0; #1 chk("normal vector R8", vector_addr, 16'hFFFC);
    monitor_mode = 1; #1 chk("monitor vector R8", vector_addr, 16'hFEFC);

    for (int i = 0; i < 3000; i++) begin
      addr = ($urandom % 3 == 0) ? {m_hi, m_lo} : 16'($urandom);
      last_cycle = ($urandom % 3 == 0);
      break_ack = ($urandom % 4 == 0);
      clr_en = $urandom % 2;
      monitor_mode = $urandom % 2;
      if ($urandom % 8 == 0) begin
        reg_addr = ($urandom % 4 == 0) ? 8'h0C + 8'($urandom % 2) : 8'h0E;
        reg_wdata = 8'($urandom);
        reg_wr = 1;
      end
      tick();
      reg_wr = 0; reg_addr = 0;
      rd(8'h0E, exp_ctl(), "random ctl R4 R9 R10");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule